// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block is a synchronous master for an 8K×8 asynchronous static RAM. A client asks for one word at a time: it raises `req` with a direction bit, a 13-bit address and, for a write, a data byte. The controller then drives the memory's select lines, write strobe and output strobe through a fixed sequence of phases. It raises `ack` for one cycle when the transfer is finished. Read data is held on `rd_data` from that cycle until the next read completes.

The memory is selected through two enables of opposite polarity, which always switch together. Each phase lasts a whole number of clock cycles, computed when the block is built. The count is the ceiling of the matching nanosecond parameter divided by the clock period, with a floor of one cycle. A write proceeds in three phases: address setup, strobe pulse, then recovery. The output strobe stays high for the whole write. The data drivers turn on only after a turnaround wait has let the memory's outputs float. A read is a single access phase with the output strobe low, and the bus is sampled on its last cycle.

Top module: `async_sram_ctl`

## Requirements
- R1: During and right after synchronous reset, `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `ack`=0.
- R2: `mem_ce` is always the inverse of `mem_ce_n`. `mem_addr` stays constant for as long as the memory is selected.
- R3: In a write, the memory is selected with the address applied for exactly SETUP = max(ceil(T_AS/CLK), ceil(T_TURN/CLK)) cycles before `mem_we_n` falls (10 at defaults).
- R4: `mem_we_n` stays low for exactly PULSE = max(ceil(T_WP/CLK), ceil(T_DW/CLK)) cycles (15 at defaults). Throughout that pulse, `mem_dq_oe`=1 and `mem_dout` carries the accepted write byte.
- R5: After `mem_we_n` rises, selection, address and data are held for RECOV = max(ceil(T_WR/CLK), ceil(T_WC/CLK) − SETUP − PULSE) cycles (25 at defaults). A write therefore keeps the memory selected for at least ceil(T_WC/CLK) cycles.
- R6: `mem_oe_n` stays high through every write. `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and never 1 outside the strobe pulse and recovery of a write.
- R7: A read keeps the memory selected with `mem_oe_n` low for exactly ACC = max(ceil(T_AA/CLK), ceil(T_OE/CLK), ceil(T_RC/CLK)) cycles (50 at defaults). `rd_data` takes the value of `mem_din` sampled on the last of those cycles.
- R8: `ack` is high for exactly one cycle, the cycle after the last phase cycle. In that cycle all strobes are inactive and `mem_dq_oe`=0.
- R9: A request is taken only when the block is idle. Changes on `req_addr` or `req_wdata` after acceptance do not affect the transfer in progress, and a `req` still high in the `ack` cycle does not start a new transfer.
- R10: A write stores `req_wdata` at `req_addr`, so a later read of that address returns the byte. Other addresses keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Transfer request, sampled in idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last read byte |
| mem_ce_n | output | 1 | Active-low memory enable |
| mem_ce | output | 1 | Active-high memory enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_addr | output | 13 | Memory address |
| mem_dout | output | 8 | Data toward the memory |
| mem_din | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Enable for the data-bus drivers |

## Verification
The bench measures every phase length at the memory pins. An off-by-one timer would stretch or shorten the strobe pulse, setup or recovery by a cycle. It also checks that the bus drivers never overlap a low output strobe, because a controller that enabled them early would fight the memory's outputs. The memory model returns wrong data until the output strobe has been low long enough, so sampling too early reads garbage. The bench also changes the request fields and holds `req` high across `ack`: a controller that followed its inputs after acceptance would write to the wrong place, and one that re-accepted in the `ack` cycle would run a phantom transfer.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WRECOV,
        ST_RACCESS,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic ce;
        logic we_n;
        logic oe_n;
        logic dq_oe;
        logic ack;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, ce: 1'b0, we_n: 1'b1,
                                        oe_n: 1'b1, dq_oe: 1'b0, ack: 1'b0};

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int SETUP_CYC = 10,
    parameter int PULSE_CYC = 15,
    parameter int RECOV_CYC = 25,
    parameter int ACC_CYC   = 50,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_we,
    input  logic             timer_done,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             accept,
    output logic             capture,
    output strobe_t          strb
);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);

    seq_state_t st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx      = st;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        capture    = 1'b0;
        unique case (st)
            ST_IDLE: if (req) begin
                accept     = 1'b1;
                timer_load = 1'b1;
                if (req_we) begin
                    st_nx     = ST_WSETUP;
                    timer_val = SETUP_LD;
                end else begin
                    st_nx     = ST_RACCESS;
                    timer_val = ACC_LD;
                end
            end
            ST_WSETUP: if (timer_done) begin
                st_nx      = ST_WPULSE;
                timer_load = 1'b1;
                timer_val  = PULSE_LD;
            end
            ST_WPULSE: if (timer_done) begin
                st_nx      = ST_WRECOV;
                timer_load = 1'b1;
                timer_val  = RECOV_LD;
            end
            ST_WRECOV: if (timer_done) st_nx = ST_DONE;
            ST_RACCESS: if (timer_done) begin
                st_nx   = ST_DONE;
                capture = 1'b1;
            end
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        strb = STROBE_IDLE;
        unique case (st)
            ST_WSETUP:  begin strb.ce_n = 1'b0; strb.ce = 1'b1; end
            ST_WPULSE:  begin strb.ce_n = 1'b0; strb.ce = 1'b1;
                              strb.we_n = 1'b0; strb.dq_oe = 1'b1; end
            ST_WRECOV:  begin strb.ce_n = 1'b0; strb.ce = 1'b1;
                              strb.dq_oe = 1'b1; end
            ST_RACCESS: begin strb.ce_n = 1'b0; strb.ce = 1'b1;
                              strb.oe_n = 1'b0; end
            ST_DONE:    strb.ack = 1'b1;
            default:    strb = STROBE_IDLE;
        endcase
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= din;
    end
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_AS_NS   = 100,
    parameter int T_WP_NS   = 150,
    parameter int T_DW_NS   = 100,
    parameter int T_WR_NS   = 50,
    parameter int T_WC_NS   = 500,
    parameter int T_AA_NS   = 500,
    parameter int T_OE_NS   = 200,
    parameter int T_RC_NS   = 500,
    parameter int T_TURN_NS = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_dq_oe
);
    localparam int SETUP_CYC = max2(ns_to_cyc(T_AS_NS, CLK_NS), ns_to_cyc(T_TURN_NS, CLK_NS));
    localparam int PULSE_CYC = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
    localparam int RECOV_CYC = max2(ns_to_cyc(T_WR_NS, CLK_NS),
                                    ns_to_cyc(T_WC_NS, CLK_NS) - SETUP_CYC - PULSE_CYC);
    localparam int ACC_CYC   = max2(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                                    ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int MAX_CYC   = max2(max2(SETUP_CYC, PULSE_CYC), max2(RECOV_CYC, ACC_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic             timer_load, timer_done, accept, capture;
    logic [CNT_W-1:0] timer_val;
    strobe_t          strb;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(timer_load), .load_val(timer_val), .done(timer_done)
    );

    sram_seq #(
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC),
        .ACC_CYC(ACC_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .timer_done(timer_done),
        .timer_load(timer_load), .timer_val(timer_val), .accept(accept),
        .capture(capture), .strb(strb)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .en(capture), .din(mem_din), .q(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            mem_dout <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dout <= req_wdata;
        end
    end

    assign ack       = strb.ack;
    assign mem_ce_n  = strb.ce_n;
    assign mem_ce    = strb.ce;
    assign mem_we_n  = strb.we_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_dq_oe = strb.dq_oe;
endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
    parameter int ADDR_W    = 13,
    parameter int PULSE_CYC = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              ack,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);
    int unsigned we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst)            we_low_cnt <= 0;
        else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1;
        else                we_low_cnt <= 0;
    end

    AST_ENABLE_PAIR: assert property (@(posedge clk) disable iff (rst)
        mem_ce == !mem_ce_n); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R2
    AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cnt == PULSE_CYC)); // R4
    AST_WE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n)); // R4
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n); // R6
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R8
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
        ack |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R8
endmodule

bind async_sram_ctl sram_ctl_checker #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst(rst), .ack(ack), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/async_sram_ctl_bench.sv
module async_sram_ctl_bench;
    localparam int AW = 13, DW = 8, CLK = 10;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic logic [7:0] init_byte(input int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
    endfunction

    localparam int E_SETUP = 10, E_PULSE = 15, E_RECOV = 25, E_ACC = 50, E_OE = 20;

    logic clk = 1'b0, rst = 1'b1, req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ack, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rd_data, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;

    always #5 clk = ~clk;

    async_sram_ctl u_async_sram_ctl (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
        .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_dq_oe(mem_dq_oe)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] model [0:(1<<AW)-1];
    logic [7:0] expm  [0:(1<<AW)-1];
    logic [7:0] cur_wdata;
    logic [AW-1:0] cur_addr;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: data valid only after output strobe low long enough
    int oe_run = 0;
    wire sel = !mem_ce_n && mem_ce;
    always_comb begin
        if (sel && !mem_oe_n && oe_run >= E_OE) mem_din = model[mem_addr];
        else                                    mem_din = ~model[mem_addr];
    end

    // pin monitor
    bit prev_sel = 0, prev_we_n = 1, prev_ack = 0, wrote = 0, bad6 = 0, bad2 = 0, in_we = 0;
    int sel_run = 0, we_run = 0, rec_run = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_ce != !mem_ce_n) bad2 = 1;
            if (sel && prev_sel && mem_addr != cur_addr) bad2 = 1;
            if (mem_dq_oe && (!mem_oe_n || mem_we_n && !in_we)) bad6 = 1;
            if (sel && !mem_oe_n && wrote) bad6 = 1;
            if (sel) sel_run++;
            if (sel && !mem_oe_n) oe_run++;
            if (!mem_we_n) begin
                if (prev_we_n) begin
                    check(sel_run - 1 == E_SETUP, "R3 setup cycles", sel_run - 1, E_SETUP);
                    check(mem_dq_oe && mem_dout == cur_wdata, "R4 data driven at strobe",
                          mem_dout, cur_wdata);
                end
                wrote = 1; in_we = 1; we_run++;
                if (sel && mem_dq_oe) model[mem_addr] = mem_dout;
            end else if (!prev_we_n) begin
                check(we_run == E_PULSE, "R4 strobe width", we_run, E_PULSE);
                rec_run = 0;
            end
            if (sel && mem_we_n && wrote) begin
                rec_run++;
                if (!mem_dq_oe || mem_dout != cur_wdata) bad6 = 1;
            end
            if (prev_sel && !sel) begin
                if (wrote) begin
                    check(rec_run == E_RECOV, "R5 recovery cycles", rec_run, E_RECOV);
                    check(!bad6, "R6 bus drive vs output strobe", bad6, 0);
                end else begin
                    check(oe_run == E_ACC, "R7 access cycles", oe_run, E_ACC);
                    check(!bad6, "R6 no drive during read", bad6, 0);
                end
                check(!bad2, "R2 enables paired, address stable", bad2, 0);
                sel_run = 0; we_run = 0; oe_run = 0; wrote = 0; in_we = 0; bad6 = 0; bad2 = 0;
            end
            if (!sel || mem_oe_n) oe_run = 0;
            if (ack) begin
                check(!prev_ack, "R8 ack one cycle", prev_ack, 0);
                check(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe,
                      "R8 strobes idle at ack",
                      {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
            end
            prev_sel = sel; prev_we_n = mem_we_n; prev_ack = ack;
        end
    end

    task automatic wait_ack();
        do @(negedge clk); while (!ack);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1; req_we = 1; req_addr = a; req_wdata = d; cur_addr = a; cur_wdata = d;
        wait_ack();
        req = 0;
        expm[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        req = 1; req_we = 0; req_addr = a; cur_addr = a;
        wait_ack();
        req = 0;
        check(rd_data == expm[a], tag, rd_data, expm[a]);
    endtask

    initial begin
        int seed;
        for (int i = 0; i < (1 << AW); i++) begin
            model[i] = init_byte(i);
            expm[i]  = init_byte(i);
        end
        repeat (3) @(negedge clk);
        check(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && !ack,
              "R1 reset strobes", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, ack},
              6'b101100);
        req = 1; req_we = 1;
        @(negedge clk);
        check(mem_ce_n && mem_we_n && !mem_dq_oe, "R1 req ignored in reset",
              {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b110);
        req = 0; rst = 0;
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && !ack, "R1 idle after reset",
              {mem_ce_n, mem_oe_n, ack}, 3'b110);

        // directed corners
        do_read(13'h0000, "R7 read initial low corner");
        do_write(13'h0000, 8'hFF);
        do_write(13'h1FFF, 8'h00);
        do_read(13'h0000, "R10 readback addr 0");
        do_read(13'h1FFF, "R10 readback top addr");
        do_read(13'h0001, "R10 neighbour untouched");

        // R9: fields change after acceptance, req held through ack
        @(negedge clk);
        req = 1; req_we = 1; req_addr = 13'h0AAA; req_wdata = 8'h5A;
        cur_addr = 13'h0AAA; cur_wdata = 8'h5A;
        @(negedge clk);
        req_addr = 13'h0555; req_wdata = 8'hC3; req_we = 0;
        repeat (20) @(negedge clk);
        check(mem_addr == 13'h0AAA && mem_dout == 8'h5A, "R9 fields frozen",
              {mem_addr, mem_dout}, {13'h0AAA, 8'h5A});
        wait_ack();
        expm[13'h0AAA] = 8'h5A;
        @(negedge clk);
        check(mem_ce_n && mem_oe_n, "R9 no restart from ack cycle", {mem_ce_n, mem_oe_n}, 2'b11);
        req = 0;
        do_read(13'h0AAA, "R9 original address written");
        do_read(13'h0555, "R9 late address untouched");

        // constrained random traffic
        seed = 32'h1234_5678;
        void'($urandom(seed));
        for (int k = 0; k < 60; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 31)) | ($urandom_range(0, 1) ? 13'h1FE0 : 13'h0000);
            if ($urandom_range(0, 1)) do_write(a, 8'($urandom()));
            else                      do_read(a, "R10 random readback");
        end
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule